// File: doc/BRIEF.md
# Dot Clock PLL Programming Sequencer

This block chooses a configuration word for a dot-clock PLL from a requested pixel clock and then walks the PLL through its reprogramming handshake. A request arrives as a frequency in kHz together with a one-cycle start strobe. The block scans a constant table of frequency and configuration-word pairs, one entry per clock, and keeps the entry whose frequency lies nearest to the request. It masks the chosen word and compares it with the word the PLL already holds.

If the PLL reports lock and already holds that word, the block finishes with no change. Otherwise it loads the word and puts the PLL into reset, turning bypass and half-pixel off in the same update. It then waits a fixed settle time, counted in system clocks, and polls the lock input once per clock up to a bounded number of samples. When the poll ends it releases reset and reports completion with a one-cycle done pulse. A timeout flag goes with done when no sample saw lock.

The block is meant to sit under a display timing controller, which issues a start whenever the pixel clock must change.

Top module: `pll_dot_clk_seq`

## Requirements
- R1: After reset, pll_cfg is 0, pll_reset is 0, pll_bypass is 1, pll_halfpix is 1, and done and timeout are 0.
- R2: Table entry i (0 to TABLE_N-1) has frequency 6200 + 100*i + 50*i*i kHz and word (i*32'h0002_9A47) ^ 32'h0000_8000. Frequencies therefore rise with i.
- R3: The selected entry has the least absolute difference between its frequency and req_khz, where req_khz is captured on the start edge. On a tie the lower index wins. The word applied to pll_cfg is the entry word ANDed with CFG_MASK (default 32'h0001_7FFF).
- R4: Let start be accepted on clock edge k. If pll_lock is 1 at edge k+TABLE_N+1 and pll_cfg already equals the masked word, done is high for the one cycle after that edge, and pll_cfg, pll_reset, pll_bypass and pll_halfpix do not change.
- R5: Otherwise, at edge k+TABLE_N+1, pll_cfg takes the masked word, pll_reset goes to 1, and pll_bypass and pll_halfpix go to 0, all at that same edge. pll_cfg then holds its value while pll_reset is high.
- R6: For the WAIT = (CLK_HZ/1000000)*SETTLE_US edges after the load, pll_lock is not looked at. A lock that rises during this window takes effect only at the first poll sample.
- R7: Lock is sampled once per clock for up to POLL_MAX samples. At the first sample that sees pll_lock high, pll_reset returns to 0 and done rises, both on that edge.
- R8: If all POLL_MAX samples see pll_lock low, pll_reset returns to 0 and done and timeout both rise on the edge of the last sample.
- R9: done is a single-cycle pulse, and timeout is never high without done.
- R10: A start, or a change of req_khz, while an operation is in progress has no effect on the word applied or on the sequence timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request strobe, taken only when idle |
| req_khz | input | 32 | Requested pixel clock in kHz |
| pll_lock | input | 1 | Lock status from the PLL |
| pll_cfg | output | 32 | Configuration word driven to the PLL |
| pll_reset | output | 1 | PLL reset control |
| pll_bypass | output | 1 | PLL bypass control |
| pll_halfpix | output | 1 | PLL half-pixel control |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | High with done when lock was never seen |

## Verification
The bench builds the block with CLK_HZ set to 1 MHz, so the settle window shrinks to 100 cycles. The table size and the 1000-sample poll limit stay at their defaults, which lets a full timeout run to its end well within the run length. A PLL model in the bench raises lock a chosen number of cycles after reset is asserted. This makes it possible to land lock inside the settle window, inside the poll window, or never. Requests at exact midpoints between neighbouring entries and at both ends of the table test the tie rule and the boundary entries.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    localparam int unsigned FREQ_W  = 32;
    localparam int unsigned F_BASE  = 6200;
    localparam int unsigned F_LIN   = 100;
    localparam int unsigned F_QUAD  = 50;
    localparam int unsigned W_MULT  = 32'h0002_9A47;
    localparam logic [31:0] W_FLIP  = 32'h0000_8000;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_SETTLE = 2'd2,
        ST_POLL   = 2'd3
    } seq_state_e;

    function automatic logic [FREQ_W-1:0] tbl_freq(input int unsigned i);
        return FREQ_W'(F_BASE + F_LIN * i + F_QUAD * i * i);
    endfunction

    function automatic logic [31:0] tbl_word(input int unsigned i);
        return 32'(i * W_MULT) ^ W_FLIP;
    endfunction

endpackage

// File: rtl/pll_table_rom.sv
module pll_table_rom
    import pll_seq_pkg::*;
#(
    parameter int unsigned TABLE_N = 80,
    localparam int unsigned IDX_W  = $clog2(TABLE_N)
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [FREQ_W-1:0] freq,
    output logic [31:0]       word
);

    logic [FREQ_W-1:0] freq_a [TABLE_N];
    logic [31:0]       word_a [TABLE_N];

    for (genvar g = 0; g < TABLE_N; g++) begin : g_entry
        assign freq_a[g] = tbl_freq(g);
        assign word_a[g] = tbl_word(g);
    end

    always_comb begin
        freq = '0;
        word = '0;
        if (32'(idx) < TABLE_N) begin
            freq = freq_a[idx];
            word = word_a[idx];
        end
    end

endmodule

// File: rtl/pll_nearest_search.sv
module pll_nearest_search
    import pll_seq_pkg::*;
#(
    parameter int unsigned TABLE_N  = 80,
    parameter logic [31:0] CFG_MASK = 32'h0001_7FFF,
    localparam int unsigned IDX_W   = $clog2(TABLE_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [FREQ_W-1:0] req_khz,
    output logic [IDX_W-1:0]  rom_idx,
    input  logic [FREQ_W-1:0] rom_freq,
    input  logic [31:0]       rom_word,
    output logic              found,
    output logic [31:0]       best_word
);

    typedef struct packed {
        logic              run;
        logic [IDX_W-1:0]  idx;
        logic [FREQ_W-1:0] req;
        logic [FREQ_W-1:0] best_diff;
        logic [31:0]       best_word;
        logic              found;
    } srch_t;

    srch_t s_d, s_q;
    logic [FREQ_W-1:0] diff;

    always_comb begin
        s_d       = s_q;
        s_d.found = 1'b0;
        diff      = (rom_freq > s_q.req) ? (rom_freq - s_q.req) : (s_q.req - rom_freq);
        if (go) begin
            s_d.run       = 1'b1;
            s_d.idx       = '0;
            s_d.req       = req_khz;
            s_d.best_diff = '1;
        end else if (s_q.run) begin
            if (diff < s_q.best_diff) begin
                s_d.best_diff = diff;
                s_d.best_word = rom_word & CFG_MASK;
            end
            if (s_q.idx == IDX_W'(TABLE_N - 1)) begin
                s_d.run   = 1'b0;
                s_d.found = 1'b1;
            end else begin
                s_d.idx = s_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rom_idx   = s_q.idx;
    assign found     = s_q.found;
    assign best_word = s_q.best_word;

endmodule

// File: rtl/pll_lock_ctrl.sv
module pll_lock_ctrl
    import pll_seq_pkg::*;
#(
    parameter int unsigned WAIT_CYC = 5000,
    parameter int unsigned POLL_MAX = 1000,
    localparam int unsigned CNT_MAX = (WAIT_CYC > POLL_MAX) ? WAIT_CYC : POLL_MAX,
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        lock,
    input  logic        found,
    input  logic [31:0] word,
    output logic        search_go,
    output logic [31:0] cfg,
    output logic        prst,
    output logic        byp,
    output logic        half,
    output logic        done,
    output logic        tmo
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [31:0]      cfg;
        logic             prst;
        logic             byp;
        logic             half;
        logic             done;
        logic             tmo;
    } ctrl_t;

    ctrl_t c_d, c_q;

    always_comb begin
        c_d      = c_q;
        c_d.done = 1'b0;
        c_d.tmo  = 1'b0;
        search_go = 1'b0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (start) begin
                    search_go = 1'b1;
                    c_d.st    = ST_SEARCH;
                end
            end
            ST_SEARCH: begin
                if (found) begin
                    if (lock && (c_q.cfg == word)) begin
                        c_d.done = 1'b1;
                        c_d.st   = ST_IDLE;
                    end else begin
                        c_d.cfg  = word;
                        c_d.prst = 1'b1;
                        c_d.byp  = 1'b0;
                        c_d.half = 1'b0;
                        c_d.cnt  = CNT_W'(WAIT_CYC - 1);
                        c_d.st   = ST_SETTLE;
                    end
                end
            end
            ST_SETTLE: begin
                if (c_q.cnt == '0) begin
                    c_d.cnt = CNT_W'(POLL_MAX - 1);
                    c_d.st  = ST_POLL;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            ST_POLL: begin
                if (lock) begin
                    c_d.prst = 1'b0;
                    c_d.done = 1'b1;
                    c_d.st   = ST_IDLE;
                end else if (c_q.cnt == '0) begin
                    c_d.prst = 1'b0;
                    c_d.done = 1'b1;
                    c_d.tmo  = 1'b1;
                    c_d.st   = ST_IDLE;
                end else begin
                    c_d.cnt = c_q.cnt - 1'b1;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q      <= '0;
            c_q.st   <= ST_IDLE;
            c_q.byp  <= 1'b1;
            c_q.half <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign cfg  = c_q.cfg;
    assign prst = c_q.prst;
    assign byp  = c_q.byp;
    assign half = c_q.half;
    assign done = c_q.done;
    assign tmo  = c_q.tmo;

endmodule

// File: rtl/pll_dot_clk_seq.sv
module pll_dot_clk_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned SETTLE_US = 100,
    parameter int unsigned POLL_MAX  = 1000,
    parameter int unsigned TABLE_N   = 80,
    parameter logic [31:0] CFG_MASK  = 32'h0001_7FFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [31:0] req_khz,
    input  logic        pll_lock,
    output logic [31:0] pll_cfg,
    output logic        pll_reset,
    output logic        pll_bypass,
    output logic        pll_halfpix,
    output logic        done,
    output logic        timeout
);

    localparam int unsigned WAIT_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
    localparam int unsigned IDX_W    = $clog2(TABLE_N);

    logic [IDX_W-1:0]  rom_idx;
    logic [FREQ_W-1:0] rom_freq;
    logic [31:0]       rom_word;
    logic              search_go;
    logic              found;
    logic [31:0]       best_word;

    pll_table_rom #(.TABLE_N(TABLE_N)) u_rom (
        .idx  (rom_idx),
        .freq (rom_freq),
        .word (rom_word)
    );

    pll_nearest_search #(.TABLE_N(TABLE_N), .CFG_MASK(CFG_MASK)) u_search (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (search_go),
        .req_khz   (req_khz),
        .rom_idx   (rom_idx),
        .rom_freq  (rom_freq),
        .rom_word  (rom_word),
        .found     (found),
        .best_word (best_word)
    );

    pll_lock_ctrl #(.WAIT_CYC(WAIT_CYC), .POLL_MAX(POLL_MAX)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .lock      (pll_lock),
        .found     (found),
        .word      (best_word),
        .search_go (search_go),
        .cfg       (pll_cfg),
        .prst      (pll_reset),
        .byp       (pll_bypass),
        .half      (pll_halfpix),
        .done      (done),
        .tmo       (timeout)
    );

endmodule

// File: rtl/pll_dot_clk_seq_chk.sv
module pll_dot_clk_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pll_cfg,
    input logic        pll_reset,
    input logic        pll_bypass,
    input logic        pll_halfpix,
    input logic        done,
    input logic        timeout
);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    timeout_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> done);

    // R5
    load_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_reset) |-> (!pll_bypass && !pll_halfpix && !done));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pll_reset && $past(pll_reset)) |-> $stable(pll_cfg));

    // R7
    release_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_reset) |-> done);

    // R4
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pll_reset && !$past(pll_reset)) |-> $stable(pll_cfg));

endmodule

bind pll_dot_clk_seq pll_dot_clk_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pll_cfg     (pll_cfg),
    .pll_reset   (pll_reset),
    .pll_bypass  (pll_bypass),
    .pll_halfpix (pll_halfpix),
    .done        (done),
    .timeout     (timeout)
);

// File: tb/pll_dot_clk_seq_tb.sv
module pll_dot_clk_seq_tb;

    localparam int N     = 80;
    localparam int WAITC = 100;
    localparam int POLLN = 1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_khz = '0;
    logic        pll_lock = 1'b0;
    logic [31:0] pll_cfg;
    logic        pll_reset, pll_bypass, pll_halfpix, done, timeout;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int lock_delay = 5;
    int rcnt = 0;
    bit rseen = 0;

    // reference model state
    int          ms = 0;
    int          mcnt = 0;
    logic [31:0] mword = '0;
    logic [31:0] e_cfg = '0;
    logic        e_rst = 0, e_byp = 1, e_half = 1, e_done = 0, e_to = 0;

    always #10 clk = ~clk;

    pll_dot_clk_seq #(.CLK_HZ(1_000_000)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req_khz),
        .pll_lock(pll_lock), .pll_cfg(pll_cfg), .pll_reset(pll_reset),
        .pll_bypass(pll_bypass), .pll_halfpix(pll_halfpix),
        .done(done), .timeout(timeout)
    );

    function automatic longint ref_freq(int i);
        return 64'(6200) + 64'(100 * i) + 64'(50 * i * i);
    endfunction

    function automatic logic [31:0] ref_pick(logic [31:0] req);
        longint bd, d;
        int best = 0;
        bd = ref_freq(0) - longint'(req);
        if (bd < 0) bd = -bd;
        for (int i = 1; i < N; i++) begin
            d = ref_freq(i) - longint'(req);
            if (d < 0) d = -d;
            if (d < bd) begin bd = d; best = i; end
        end
        return (32'(best * 170567) ^ 32'h0000_8000) & 32'h0001_7FFF;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // cycle model
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            ms = 0; e_cfg = '0; e_rst = 0; e_byp = 1; e_half = 1; e_done = 0; e_to = 0;
        end else begin
            e_done = 0; e_to = 0;
            case (ms)
                0: if (start) begin ms = 1; mcnt = 0; mword = ref_pick(req_khz); end
                1: begin
                    mcnt++;
                    if (mcnt == N + 1) begin
                        if (pll_lock && e_cfg == mword) begin e_done = 1; ms = 0; end
                        else begin
                            e_cfg = mword; e_rst = 1; e_byp = 0; e_half = 0;
                            ms = 2; mcnt = 0;
                        end
                    end
                end
                2: begin mcnt++; if (mcnt == WAITC) begin ms = 3; mcnt = 0; end end
                default: begin
                    mcnt++;
                    if (pll_lock) begin e_rst = 0; e_done = 1; ms = 0; end
                    else if (mcnt == POLLN) begin e_rst = 0; e_done = 1; e_to = 1; ms = 0; end
                end
            endcase
        end
    end

    // compare every cycle, then update the PLL model
    always @(negedge clk) begin
        if (rst_n) begin
            check(pll_cfg == e_cfg, "R5 cfg", pll_cfg, e_cfg);
            check(pll_reset == e_rst, "R7 reset", 32'(pll_reset), 32'(e_rst));
            check(pll_bypass == e_byp, "R5 bypass", 32'(pll_bypass), 32'(e_byp));
            check(pll_halfpix == e_half, "R5 halfpix", 32'(pll_halfpix), 32'(e_half));
            check(done == e_done, "R9 done", 32'(done), 32'(e_done));
            check(timeout == e_to, "R8 timeout", 32'(timeout), 32'(e_to));
        end
        if (pll_reset && !rseen) begin
            rseen = 1; rcnt = 0; pll_lock = 0;
        end else if (pll_reset) begin
            rcnt++;
            if (rcnt >= lock_delay) pll_lock = 1;
        end
        if (!pll_reset) rseen = 0;
    end

    task automatic run(logic [31:0] req, int dly, bit glitch, bit exp_to,
                       int exp_lat, string tag);
        int n = 0;
        bit seen = 0;
        lock_delay = dly;
        @(negedge clk); start = 1; req_khz = req;
        @(negedge clk); start = 0;
        while (!seen && n < 3000) begin
            if (glitch && n == 3) begin start = 1; req_khz = 32'd320000; end
            if (glitch && n == 4) start = 0;
            if (glitch && n == N + 10) begin start = 1; req_khz = 32'd6000; end
            if (glitch && n == N + 11) start = 0;
            @(negedge clk); n++;
            if (done) seen = 1;
        end
        check(seen, {tag, " done seen"}, 32'(seen), 32'd1);
        check(pll_cfg == ref_pick(req), {tag, " word"}, pll_cfg, ref_pick(req));
        check(timeout == exp_to, {tag, " timeout flag"}, 32'(timeout), 32'(exp_to));
        if (exp_lat > 0) check(n == exp_lat, {tag, " latency"}, n, exp_lat);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pll_cfg == 0, "R1 cfg", pll_cfg, 0);
        check(pll_bypass == 1 && pll_halfpix == 1, "R1 bypass/halfpix",
              {pll_bypass, pll_halfpix}, 2'b11);
        check(!pll_reset && !done && !timeout, "R1 reset/done/timeout",
              {pll_reset, done, timeout}, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        // R5 R6: lock arrives during settle, seen at first poll sample
        run(32'd25000, 5, 0, 0, N + 1 + WAITC + 1, "R6 early lock");
        // R4: same target while locked is skipped
        run(32'd25000, 5, 0, 0, N + 1, "R4 skip");
        // R7: lock arrives mid-poll
        run(32'd100000, 150, 0, 0, N + 1 + 150 + 1, "R7 poll lock");
        // R3: tie between entries 10 and 11 picks 10
        run(32'(ref_freq(10) + 75 + 500), 3, 0, 0, 0, "R3 tie");
        // R2 R3: both ends of the table
        run(32'd0, 3, 0, 0, 0, "R2 low end");
        run(32'd900000, 3, 0, 0, 0, "R2 high end");
        // R10: starts and request changes during search and settle
        run(32'd60000, 8, 1, 0, N + 1 + WAITC + 1, "R10 busy start");
        // R8: no lock within the poll limit
        run(32'd150000, 1_000_000, 0, 1, N + 1 + WAITC + POLLN, "R8 timeout");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #3_800_000;
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule